// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

This block takes one DMA transfer at a time from a requester and turns it into a series of memory requests, none of which crosses a cache-line boundary. A transfer is given by a start byte address, a byte length, a direction flag and, for writes, the bytes to store. The first request covers the bytes from the start address up to the end of its line, or to the end of the transfer if that comes sooner. Every later request starts on a line boundary and covers a full line, or whatever is left of the transfer.

Only one memory request is outstanding at a time. The sequencer offers a request on a valid/ready port and holds it unchanged until it is taken. It then waits for a single response: an acknowledgement for a store, or a full line of data for a load. Load bytes are collected into a result buffer at their position within the transfer. When the last response arrives, the sequencer raises a one-cycle completion pulse. In that same cycle it becomes able to take the next transfer.

Top module: `dma_line_seq`

## Requirements
- R1: While a transfer is active, `req_ready` is 0. A `req_valid` presented while `req_ready` is 0 is not taken and does not change the active transfer. In that case `req_refused` is 1 in the cycle after.
- R2: The first memory request has `mem_offset` equal to the low log2(LINE_BYTES) bits of the start address. Its `mem_line_addr` is the start address with those bits cleared. Its `mem_len` is the smaller of the transfer length and LINE_BYTES minus `mem_offset`.
- R3: Each later memory request has `mem_line_addr` equal to the start address plus the bytes already completed, with low bits zero. Its `mem_offset` is 0 and its `mem_len` is the smaller of the remaining bytes and LINE_BYTES.
- R4: A request that is not accepted (`mem_valid`=1, `mem_ready`=0) stays valid with all its fields unchanged in the next cycle. After a request is accepted, `mem_valid` stays 0 until a response (`rsp_valid`) has arrived.
- R5: For a store (`mem_store`=1), byte `mem_offset`+k of `mem_wdata` (byte 0 = bits 7:0) is byte P+k of `req_wdata`, where P is the number of transfer bytes sent before this request. All bytes outside the chunk are 0.
- R6: For a load, byte C+k of `rd_data` is byte S+k of `rsp_data` for k below the chunk length. Here C is the number of bytes completed before the response, and S is the start offset for the first chunk and 0 for later ones.
- R7: `done` is 1 for exactly one cycle after the last response is taken, and `req_ready` is 1 in that same cycle. A request presented in that cycle is accepted.
- R8: A transfer of length 0 is accepted, issues no memory request, and gives `done`=1 in the next cycle.
- R9: `rsp_valid` is ignored while idle or while a request is still waiting to be accepted. It does not change `rd_data`, `done` or the request sequence.
- R10: After reset, `mem_valid`, `done` and `req_refused` are 0, `req_ready` is 1 and `rd_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester presents a transfer |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes (0..MAX_BYTES) |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_wdata | input | MAX_BYTES*8 | Write bytes, byte k at bits 8k+7:8k |
| req_ready | output | 1 | Sequencer idle, can take a transfer |
| req_refused | output | 1 | Previous-cycle request was refused as busy |
| done | output | 1 | One-cycle transfer completion pulse |
| rd_data | output | MAX_BYTES*8 | Gathered read bytes |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_line_addr | output | ADDR_W | Line-aligned request address |
| mem_offset | output | OFF_W | Byte offset of the chunk within the line |
| mem_len | output | OFF_W+1 | Chunk length in bytes |
| mem_store | output | 1 | 1 = store, 0 = load |
| mem_wdata | output | LINE_BYTES*8 | Store line data, chunk placed at offset |
| rsp_valid | input | 1 | Response (ack or load data) |
| rsp_data | input | LINE_BYTES*8 | Returned line for loads |

## Verification
Two events can fall in the same cycle: the completion of one transfer and the acceptance of the next. The stimulus table is walked with no idle gap, so each new transfer is presented in the exact cycle in which `done` shows for the previous one. The bench judges this by seeing `req_ready` high at that point, and by checking that the following transfer's first chunk comes out with correct fields. A refused request is also placed in a cycle where a chunk is outstanding. The bench checks that the refusal flag rises and that the ongoing chunk sequence is undisturbed.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dls_chunk_calc.sv
// Chunk length: the smaller of the bytes left and the room left in the line.
module dls_chunk_calc #(
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  remaining,
  output logic [CLEN_W-1:0] clen
);
  localparam int CMP_W = (LEN_W > CLEN_W) ? LEN_W : CLEN_W;

  logic [CLEN_W-1:0] room;
  logic [CMP_W-1:0]  rem_w;
  logic [CMP_W-1:0]  room_w;

  always_comb begin
    room   = CLEN_W'(LINE_BYTES) - {1'b0, off};
    rem_w  = CMP_W'(remaining);
    room_w = CMP_W'(room);
    clen   = (rem_w < room_w) ? CLEN_W'(rem_w) : room;
  end
endmodule

// File: rtl/dls_line_pack.sv
// Places a run of transfer bytes into a line at a given offset, zero elsewhere.
module dls_line_pack #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 128,
  parameter int LEN_W      = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1
) (
  input  logic [MAX_BYTES*8-1:0]  src_buf,
  input  logic [LEN_W-1:0]        src_pos,
  input  logic [OFF_W-1:0]        off,
  input  logic [CLEN_W-1:0]       clen,
  output logic [LINE_BYTES*8-1:0] line
);
  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
    int rel;
    int idx;
    always_comb begin
      rel = i - int'(off);
      idx = int'(src_pos) + rel;
      if (rel >= 0 && rel < int'(clen) && idx < MAX_BYTES)
        line[i*8 +: 8] = src_buf[idx*8 +: 8];
      else
        line[i*8 +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/dls_gather.sv
// Result buffer: copies a chunk of a returned line into transfer position.
module dls_gather #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 128,
  parameter int LEN_W      = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [LEN_W-1:0]        dst_pos,
  input  logic [OFF_W-1:0]        src_off,
  input  logic [CLEN_W-1:0]       clen,
  input  logic [LINE_BYTES*8-1:0] line_in,
  output logic [MAX_BYTES*8-1:0]  buf_q
);
  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_slot
    int   rel;
    int   sidx;
    logic hit;
    logic [7:0] val;
    always_comb begin
      rel  = j - int'(dst_pos);
      sidx = rel + int'(src_off);
      hit  = (rel >= 0) && (rel < int'(clen)) && (sidx < LINE_BYTES);
      val  = hit ? line_in[sidx*8 +: 8] : 8'h00;
    end
    always_ff @(posedge clk) begin
      if (rst)
        buf_q[j*8 +: 8] <= 8'h00;
      else if (we && hit)
        buf_q[j*8 +: 8] <= val;
    end
  end
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
  import dls_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 128,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    req_write,
  input  logic [MAX_BYTES*8-1:0]  req_wdata,
  output logic                    req_ready,
  output logic                    req_refused,
  output logic                    done,
  output logic [MAX_BYTES*8-1:0]  rd_data,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [ADDR_W-1:0]       mem_line_addr,
  output logic [OFF_W-1:0]        mem_offset,
  output logic [CLEN_W-1:0]       mem_len,
  output logic                    mem_store,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    rsp_valid,
  input  logic [LINE_BYTES*8-1:0] rsp_data
);
  seq_state_e              state_q;
  logic [ADDR_W-1:0]       start_q;
  logic [LEN_W-1:0]        total_q;
  logic [LEN_W-1:0]        issued_q;
  logic [LEN_W-1:0]        completed_q;
  logic                    write_q;
  logic [MAX_BYTES*8-1:0]  wbuf_q;
  logic [OFF_W-1:0]        cur_off_q;
  logic [CLEN_W-1:0]       cur_len_q;
  logic [ADDR_W-1:0]       line_q;
  logic [LINE_BYTES*8-1:0] wline_q;
  logic                    done_q;
  logic                    refused_q;

  logic                    idle;
  logic [OFF_W-1:0]        nxt_off;
  logic [LEN_W-1:0]        nxt_rem;
  logic [CLEN_W-1:0]       nxt_clen;
  logic [ADDR_W-1:0]       nxt_line;
  logic [MAX_BYTES*8-1:0]  pack_src;
  logic [LEN_W-1:0]        pack_pos;
  logic [LINE_BYTES*8-1:0] packed_line;
  logic                    gather_we;

  // Shared next-chunk datapath: from the request when idle, from state otherwise.
  always_comb begin
    idle     = (state_q == ST_IDLE);
    nxt_off  = idle ? req_addr[OFF_W-1:0] : '0;
    nxt_rem  = idle ? req_len : (total_q - issued_q);
    nxt_line = idle ? {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                    : (start_q + ADDR_W'(issued_q));
    pack_src = idle ? req_wdata : wbuf_q;
    pack_pos = idle ? '0 : issued_q;
  end

  dls_chunk_calc #(
    .LINE_BYTES(LINE_BYTES),
    .LEN_W     (LEN_W)
  ) u_calc (
    .off      (nxt_off),
    .remaining(nxt_rem),
    .clen     (nxt_clen)
  );

  dls_line_pack #(
    .LINE_BYTES(LINE_BYTES),
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W)
  ) u_pack (
    .src_buf(pack_src),
    .src_pos(pack_pos),
    .off    (nxt_off),
    .clen   (nxt_clen),
    .line   (packed_line)
  );

  assign gather_we = (state_q == ST_WAIT) && rsp_valid && !write_q;

  // Later chunks carry offset 0, so the current offset is the source offset.
  dls_gather #(
    .LINE_BYTES(LINE_BYTES),
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W)
  ) u_gather (
    .clk    (clk),
    .rst    (rst),
    .we     (gather_we),
    .dst_pos(completed_q),
    .src_off(cur_off_q),
    .clen   (cur_len_q),
    .line_in(rsp_data),
    .buf_q  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      start_q     <= '0;
      total_q     <= '0;
      issued_q    <= '0;
      completed_q <= '0;
      write_q     <= 1'b0;
      wbuf_q      <= '0;
      cur_off_q   <= '0;
      cur_len_q   <= '0;
      line_q      <= '0;
      wline_q     <= '0;
      done_q      <= 1'b0;
      refused_q   <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      refused_q <= req_valid && !idle;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            start_q     <= req_addr;
            total_q     <= req_len;
            write_q     <= req_write;
            wbuf_q      <= req_wdata;
            completed_q <= '0;
            if (req_len == '0) begin
              issued_q <= '0;
              done_q   <= 1'b1;
            end else begin
              state_q   <= ST_SEND;
              issued_q  <= LEN_W'(nxt_clen);
              cur_off_q <= nxt_off;
              cur_len_q <= nxt_clen;
              line_q    <= nxt_line;
              wline_q   <= req_write ? packed_line : '0;
            end
          end
        end
        ST_SEND: begin
          if (mem_ready)
            state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            completed_q <= issued_q;
            if (issued_q == total_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q   <= ST_SEND;
              issued_q  <= issued_q + LEN_W'(nxt_clen);
              cur_off_q <= nxt_off;
              cur_len_q <= nxt_clen;
              line_q    <= nxt_line;
              wline_q   <= write_q ? packed_line : '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign req_refused   = refused_q;
  assign done          = done_q;
  assign mem_valid     = (state_q == ST_SEND);
  assign mem_line_addr = line_q;
  assign mem_offset    = cur_off_q;
  assign mem_len       = cur_len_q;
  assign mem_store     = write_q;
  assign mem_wdata     = wline_q;
endmodule

// File: rtl/dls_seq_checker.sv
module dls_seq_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_refused,
  input logic                    done,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [ADDR_W-1:0]       mem_line_addr,
  input logic [OFF_W-1:0]        mem_offset,
  input logic [CLEN_W-1:0]       mem_len,
  input logic [LINE_BYTES*8-1:0] mem_wdata
);
  p_refuse_busy_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_refused);

  p_chunk_in_line_r2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_len != '0) &&
      (({1'b0, 1'b0, mem_offset} + {1'b0, mem_len}) <= (CLEN_W+1)'(LINE_BYTES)));

  p_line_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_line_addr[OFF_W-1:0] == '0));

  p_hold_request_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_line_addr) &&
      $stable(mem_offset) && $stable(mem_len) && $stable(mem_wdata));

  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready |=> !mem_valid);

  p_done_frees_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready && !req_valid |=> !mem_valid && req_ready);
endmodule

bind dma_line_seq dls_seq_checker #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_refused  (req_refused),
  .done         (done),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_line_addr(mem_line_addr),
  .mem_offset   (mem_offset),
  .mem_len      (mem_len),
  .mem_wdata    (mem_wdata)
);

// File: tb/dma_line_seq_test.sv
`timescale 1ns/1ps
module dma_line_seq_test;
  localparam int AW   = 32;
  localparam int LB   = 64;
  localparam int MB   = 128;
  localparam int OW   = 6;
  localparam int LW   = 8;
  localparam int NVEC = 8;

  // {addr[31:0], len[7:0], write, stall, poke}
  localparam logic [42:0] VEC [NVEC] = '{
    {32'h0000_0100, 8'd16,  1'b0, 1'b0, 1'b0},
    {32'h0000_0130, 8'd16,  1'b0, 1'b0, 1'b0},
    {32'h0000_013C, 8'd40,  1'b0, 1'b1, 1'b1},
    {32'h0000_0205, 8'd128, 1'b1, 1'b0, 1'b0},
    {32'h0000_0205, 8'd128, 1'b0, 1'b0, 1'b0},
    {32'h0000_0340, 8'd64,  1'b1, 1'b1, 1'b1},
    {32'h0000_033F, 8'd66,  1'b0, 1'b0, 1'b0},
    {32'h0000_0080, 8'd1,   1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic req_write = 1'b0;
  logic [MB*8-1:0] req_wdata = '0;
  logic req_ready, req_refused, done;
  logic [MB*8-1:0] rd_data;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [AW-1:0] mem_line_addr;
  logic [OW-1:0] mem_offset;
  logic [OW:0]   mem_len;
  logic mem_store;
  logic [LB*8-1:0] mem_wdata;
  logic rsp_valid = 1'b0;
  logic [LB*8-1:0] rsp_data = '0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [0:1023];

  always #4 clk = ~clk;

  dma_line_seq #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_BYTES(MB)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_refused(req_refused), .done(done),
    .rd_data(rd_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_line_addr(mem_line_addr), .mem_offset(mem_offset), .mem_len(mem_len),
    .mem_store(mem_store), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wpat(input int seed, input int k);
    return 8'((k * 13 + seed) & 255);
  endfunction

  task automatic do_xfer(input logic [31:0] a, input int n, input bit wr,
                         input bit stall, input bit poke, input int seed);
    int pos;
    int k;
    int eoff;
    int elen;
    logic [31:0] eline;
    logic [LB*8-1:0] ewd;
    logic [AW-1:0] held_addr;
    logic [LB*8-1:0] held_wd;
    bit bad;
    req_addr  = a;
    req_len   = LW'(n);
    req_write = wr;
    for (int b = 0; b < MB; b++) req_wdata[b*8 +: 8] = wpat(seed, b);
    req_valid = 1'b1;
    check(req_ready == 1'b1, "R7 ready at request", longint'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      check(done == 1'b1, "R8 zero-length done", longint'(done), 1);
      check(mem_valid == 1'b0, "R8 no memory request", longint'(mem_valid), 0);
      return;
    end
    pos = 0;
    k = 0;
    while (pos < n) begin
      eoff  = (k == 0) ? int'(a % LB) : 0;
      eline = (k == 0) ? (a & ~32'(LB - 1)) : (a + 32'(pos));
      elen  = ((n - pos) < (LB - eoff)) ? (n - pos) : (LB - eoff);
      check(mem_valid == 1'b1, "R4 request valid", longint'(mem_valid), 1);
      check(mem_line_addr == eline, (k == 0) ? "R2 line addr" : "R3 line addr",
            longint'(mem_line_addr), longint'(eline));
      check(int'(mem_offset) == eoff, (k == 0) ? "R2 offset" : "R3 offset",
            longint'(mem_offset), longint'(eoff));
      check(int'(mem_len) == elen, (k == 0) ? "R2 length" : "R3 length",
            longint'(mem_len), longint'(elen));
      check(mem_store == wr, "R5 type", longint'(mem_store), longint'(wr));
      ewd = '0;
      for (int b = 0; b < LB; b++)
        if (b >= eoff && b < eoff + elen) ewd[b*8 +: 8] = wpat(seed, pos + b - eoff);
      if (wr) begin
        bad = (mem_wdata != ewd);
        check(!bad, "R5 store line data", longint'(mem_wdata[63:0]), longint'(ewd[63:0]));
      end
      if (stall) begin
        held_addr = mem_line_addr;
        held_wd   = mem_wdata;
        rsp_valid = 1'b1;
        for (int b = 0; b < LB; b++) rsp_data[b*8 +: 8] = 8'hE7;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(mem_valid && mem_line_addr == held_addr && mem_wdata == held_wd &&
              int'(mem_len) == elen, "R4 held while not ready (R9 early rsp ignored)",
              longint'(mem_line_addr), longint'(held_addr));
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      check(mem_valid == 1'b0, "R4 no second request", longint'(mem_valid), 0);
      if (poke && k == 0) begin
        req_valid = 1'b1;
        req_addr  = 32'h0000_0000;
        req_len   = LW'(3);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_refused == 1'b1, "R1 refused flag", longint'(req_refused), 1);
        check(req_ready == 1'b0, "R1 busy", longint'(req_ready), 0);
      end else begin
        @(negedge clk);
      end
      check(mem_valid == 1'b0, "R4 waiting for response", longint'(mem_valid), 0);
      if (wr) begin
        for (int b = eoff; b < eoff + elen; b++)
          model[(eline + 32'(b)) & 32'h3FF] = ewd[b*8 +: 8];
        for (int b = 0; b < LB; b++) rsp_data[b*8 +: 8] = 8'h5A;
      end else begin
        for (int b = 0; b < LB; b++) rsp_data[b*8 +: 8] = model[(eline + 32'(b)) & 32'h3FF];
      end
      rsp_valid = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;
      pos += elen;
      k++;
      if (pos == n) begin
        check(done == 1'b1, "R7 done pulse", longint'(done), 1);
        check(req_ready == 1'b1, "R7 ready with done", longint'(req_ready), 1);
      end else begin
        check(done == 1'b0, "R7 no early done", longint'(done), 0);
      end
    end
    if (!wr) begin
      bad = 1'b0;
      for (int b = 0; b < n; b++)
        if (rd_data[b*8 +: 8] != model[(a + 32'(b)) & 32'h3FF]) bad = 1'b1;
      check(!bad, "R6 gathered read bytes", longint'(rd_data[63:0]),
            longint'({model[(a+7)&32'h3FF], model[(a+6)&32'h3FF], model[(a+5)&32'h3FF],
                      model[(a+4)&32'h3FF], model[(a+3)&32'h3FF], model[(a+2)&32'h3FF],
                      model[(a+1)&32'h3FF], model[a&32'h3FF]}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [MB*8-1:0] saved;
    for (int i = 0; i < 1024; i++) model[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(mem_valid == 1'b0, "R10 reset mem_valid", longint'(mem_valid), 0);
    check(done == 1'b0, "R10 reset done", longint'(done), 0);
    check(req_ready == 1'b1, "R10 reset ready", longint'(req_ready), 1);
    check(req_refused == 1'b0, "R10 reset refused", longint'(req_refused), 0);
    check(rd_data == '0, "R10 reset rd_data", longint'(rd_data[63:0]), 0);

    // Table walk: each transfer starts in the cycle the previous one completes.
    for (int v = 0; v < NVEC; v++)
      do_xfer(VEC[v][42:11], int'(VEC[v][10:3]), VEC[v][2], VEC[v][1], VEC[v][0], v * 17 + 1);

    // R8: zero length, directly after the last table transfer's done.
    do_xfer(32'h0000_0011, 0, 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done is one cycle", longint'(done), 0);

    // R9: responses while idle are ignored.
    saved = rd_data;
    rsp_valid = 1'b1;
    for (int b = 0; b < LB; b++) rsp_data[b*8 +: 8] = 8'hC3;
    repeat (2) @(negedge clk);
    rsp_valid = 1'b0;
    check(mem_valid == 1'b0, "R9 idle rsp no request", longint'(mem_valid), 0);
    check(done == 1'b0, "R9 idle rsp no done", longint'(done), 0);
    check(rd_data == saved, "R9 idle rsp rd_data kept", longint'(rd_data[63:0]),
          longint'(saved[63:0]));

    // After the idle responses, a single-chunk read still runs normally.
    do_xfer(32'h0000_03F0, 16, 1'b0, 1'b0, 1'b0, 5);
    @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule